// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block sits beside a processor core and decides which event the core must service next. It watches sixteen event levels with fixed priorities. Level 0 is the most urgent. The levels are, in order: emulation, reset, nonmaskable interrupt, exception, one reserved slot, hardware error, core timer, and nine general-purpose interrupt levels. Requests are latched, so a short pulse is enough to raise one. Levels from five upward pass through a per-level enable mask. A set of in-service bits records which handlers are running, so that handlers can nest: a new event interrupts the running handler only when its priority is strictly higher than that of every active level.

For each grant the block raises a take strobe for one cycle and presents the level number. When a handler finishes, the core pulses a return input, which retires the most urgent active level. The exception path can bypass the request latch. A synchronous fault is then taken in the cycle it is raised, before the faulting instruction can complete. Two inputs, a watchdog-timeout line and an external pin, both request the nonmaskable level. A level-and-strobe pair lets software raise any general-purpose level. When reset is released, a grant of the reset level is forced.

Top module: `nest_evt_ctrl`

## Requirements
- R1: When no level is active, the lowest-numbered pending, enabled level is granted. `take_evt` is 1 for that cycle and `evt_idx` holds the level number (0 to 15). At most one level is granted per cycle, and `evt_idx` reads 0 when `take_evt` is 0.
- R2: Level 4 is never latched and never granted. A software raise aimed at level 4 has no visible effect on `take_evt`.
- R3: While any level is active, a pending level is granted only if its number is strictly smaller than every active level. Equal or larger levels stay pending.
- R4: `gp_req[i]` requests level 7+i. A `sw_raise` pulse requests level `sw_level` when `sw_level` is 7 to 15, and is ignored for values 0 to 6.
- R5: Level 2 is requested by `nmi_pin` OR `wdog_to`.
- R6: When no level 0 to 2 is pending and no level 0 to 3 is active, `exc_req` gives `take_evt`=1 with `evt_idx`=3 in the same cycle, ahead of any pending level 5 to 15. Otherwise the exception is latched and waits.
- R7: A `mask_wr` pulse loads `mask_wdata`, and the new mask applies from the next cycle. Bit i enables level i for levels 5 to 15. Levels 0 to 3 ignore the mask. The mask resets to all zeros.
- R8: A latched request stays pending until it is granted. The grant clears that pending bit and sets the matching in-service bit at the same clock edge.
- R9: An `evt_ret` pulse clears only the in-service bit of the lowest-numbered active level. With no level active it does nothing.
- R10: Reset clears all pending, in-service and mask state. In the first cycle after reset is released, `take_evt`=1 with `evt_idx`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_req | input | 1 | Emulation request, level 0 |
| nmi_pin | input | 1 | External nonmaskable request, level 2 |
| wdog_to | input | 1 | Watchdog timeout, level 2 |
| exc_req | input | 1 | Synchronous exception, level 3 |
| hwerr_req | input | 1 | Hardware error, level 5 |
| tmr_req | input | 1 | Core timer, level 6 |
| gp_req | input | 9 | General requests, bit i is level 7+i |
| sw_raise | input | 1 | Software raise strobe |
| sw_level | input | 4 | Level raised by `sw_raise` |
| mask_wr | input | 1 | Mask load strobe |
| mask_wdata | input | 16 | New mask, bit i for level i |
| evt_ret | input | 1 | Return from the current event |
| take_evt | output | 1 | Grant strobe |
| evt_idx | output | 4 | Granted level |

## Verification
A request on a latched input appears as a grant in the cycle after the edge that captures it. A mask write applies to the grant decision one cycle after the write. An exception with the bypass enabled is granted combinationally in the cycle it is raised. A return changes which level may be granted from the next cycle on. The bench drives each input just after a falling edge and samples `take_evt` and `evt_idx` one nanosecond later, within the same cycle. It compares them with a bench model that advances only at the rising edge, and the directed checks name the exact cycle at which each grant is due.

// File: rtl/nest_evt_pkg.sv
package nest_evt_pkg;
   localparam int unsigned LVL_EMU = 0;
   localparam int unsigned LVL_RST = 1;
   localparam int unsigned LVL_NMI = 2;
   localparam int unsigned LVL_EXC = 3;
   localparam int unsigned LVL_RSV = 4;
   localparam int unsigned LVL_HWE = 5;
   localparam int unsigned LVL_TMR = 6;
   localparam int unsigned LVL_GP0 = 7;
endpackage

// File: rtl/nest_evt_prio.sv
module nest_evt_prio #(
   parameter int unsigned W  = 16,
   parameter int unsigned IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (W < 2) begin : g_bad_w
      $error("nest_evt_prio: W must be at least 2");
   end

   always_comb begin
      idx   = '0;
      found = |vec;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/nest_evt_pend.sv
module nest_evt_pend #(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned RSV_LVL = 4,
   parameter int unsigned BOOT_LVL = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] set_vec,
   input  logic [NUM_LVL-1:0] clr_vec,
   input  logic               mask_wr,
   input  logic [NUM_LVL-1:0] mask_wdata,
   output logic [NUM_LVL-1:0] pend_q,
   output logic [NUM_LVL-1:0] mask_q
);
   localparam logic [NUM_LVL-1:0] RSV_VEC  = NUM_LVL'(1) << RSV_LVL;
   localparam logic [NUM_LVL-1:0] BOOT_VEC = NUM_LVL'(1) << BOOT_LVL;

   if (RSV_LVL >= NUM_LVL || BOOT_LVL >= NUM_LVL) begin : g_bad_lvl
      $error("nest_evt_pend: level out of range");
   end

   logic [NUM_LVL-1:0] pend_n;

   always_comb begin
      pend_n = ((pend_q | set_vec) & ~clr_vec) & ~RSV_VEC;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= BOOT_VEC;
         mask_q <= '0;
      end else begin
         pend_q <= pend_n;
         if (mask_wr) mask_q <= mask_wdata;
      end
   end

   // R8: a pending bit that was not cleared stays set
   p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));

   // R2: the reserved bit never becomes pending
   p_rsv_unlatched_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> !pend_q[RSV_LVL]);
endmodule

// File: rtl/nest_evt_nest.sv
module nest_evt_nest #(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned IW = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [IW-1:0]      set_idx,
   input  logic               ret,
   output logic               top_found,
   output logic [IW-1:0]      top_idx
);
   logic [NUM_LVL-1:0] act_q;
   logic [NUM_LVL-1:0] act_n;

   nest_evt_prio #(.W(NUM_LVL), .IW(IW)) u_top (
      .vec   (act_q),
      .found (top_found),
      .idx   (top_idx)
   );

   always_comb begin
      act_n = act_q;
      if (ret && top_found) act_n[top_idx] = 1'b0;
      if (set_en) act_n[set_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= '0;
      else        act_q <= act_n;
   end

   // R3: a new handler is only started strictly above every active one
   p_nest_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && top_found) |-> (set_idx < top_idx));

   // R9: a return retires the most urgent active level
   p_ret_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && top_found) |=> !act_q[$past(top_idx)]);

   // R9: only that one level is retired
   p_ret_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && top_found && !set_en) |=> ($countones(act_q) == $countones($past(act_q)) - 1));

   // R8: a grant leaves its level in service
   p_set_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> act_q[$past(set_idx)]);
endmodule

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl
   import nest_evt_pkg::*;
#(
   parameter int unsigned NUM_LVL    = 16,
   parameter int unsigned MASK_FROM  = 4,
   parameter bit          EXC_BYPASS = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          emu_req,
   input  logic                          nmi_pin,
   input  logic                          wdog_to,
   input  logic                          exc_req,
   input  logic                          hwerr_req,
   input  logic                          tmr_req,
   input  logic [NUM_LVL-LVL_GP0-1:0]    gp_req,
   input  logic                          sw_raise,
   input  logic [$clog2(NUM_LVL)-1:0]    sw_level,
   input  logic                          mask_wr,
   input  logic [NUM_LVL-1:0]            mask_wdata,
   input  logic                          evt_ret,
   output logic                          take_evt,
   output logic [$clog2(NUM_LVL)-1:0]    evt_idx
);
   localparam int unsigned IW   = $clog2(NUM_LVL);
   localparam int unsigned GP_N = NUM_LVL - LVL_GP0;
   localparam logic [IW-1:0] RSV_IDX = IW'(LVL_RSV);
   localparam logic [IW-1:0] EXC_IDX = IW'(LVL_EXC);
   localparam logic [IW-1:0] GP0_IDX = IW'(LVL_GP0);
   localparam logic [IW-1:0] MSK_IDX = IW'(MASK_FROM);
   localparam logic [NUM_LVL-1:0] NMASK_VEC = (NUM_LVL'(1) << MASK_FROM) - NUM_LVL'(1);
   localparam logic [NUM_LVL-1:0] RSV_VEC   = NUM_LVL'(1) << LVL_RSV;
   localparam logic [NUM_LVL-1:0] ABOVE_EXC = (NUM_LVL'(1) << LVL_EXC) - NUM_LVL'(1);

   if (NUM_LVL <= LVL_GP0 || NUM_LVL > 64) begin : g_bad_num
      $error("nest_evt_ctrl: NUM_LVL out of range");
   end
   if (MASK_FROM <= LVL_EXC || MASK_FROM > LVL_HWE) begin : g_bad_mask
      $error("nest_evt_ctrl: MASK_FROM must keep levels 0 to 3 unmaskable");
   end

   logic [NUM_LVL-1:0] new_req;
   logic [NUM_LVL-1:0] pend_q;
   logic [NUM_LVL-1:0] mask_q;
   logic [NUM_LVL-1:0] live;
   logic [NUM_LVL-1:0] en_vec;
   logic [NUM_LVL-1:0] elig;
   logic [NUM_LVL-1:0] clr_vec;
   logic               cand_found;
   logic [IW-1:0]      cand_idx;
   logic               act_found;
   logic [IW-1:0]      act_top;
   logic               grant;
   logic               boot_q;

   always_comb begin
      new_req = '0;
      new_req[LVL_EMU] = emu_req;
      new_req[LVL_NMI] = nmi_pin | wdog_to;
      new_req[LVL_EXC] = exc_req;
      new_req[LVL_HWE] = hwerr_req;
      new_req[LVL_TMR] = tmr_req;
      for (int i = 0; i < GP_N; i++) begin
         new_req[LVL_GP0 + i] = gp_req[i];
      end
      if (sw_raise && sw_level >= GP0_IDX) new_req[sw_level] = 1'b1;
   end

   nest_evt_pend #(.NUM_LVL(NUM_LVL), .RSV_LVL(LVL_RSV), .BOOT_LVL(LVL_RST)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (new_req),
      .clr_vec    (clr_vec),
      .mask_wr    (mask_wr),
      .mask_wdata (mask_wdata),
      .pend_q     (pend_q),
      .mask_q     (mask_q)
   );

   if (EXC_BYPASS) begin : g_exc_bypass
      always_comb begin
         live = pend_q;
         live[LVL_EXC] = pend_q[LVL_EXC] | exc_req;
      end

      // R6: an unobstructed exception is taken in the cycle it is raised
      p_exc_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (exc_req && !(|(pend_q & ABOVE_EXC)) && !(act_found && act_top <= EXC_IDX))
         |-> (take_evt && evt_idx == EXC_IDX));
   end else begin : g_exc_latched
      always_comb live = pend_q;
   end

   always_comb begin
      en_vec = (mask_q | NMASK_VEC) & ~RSV_VEC;
      elig   = live & en_vec;
   end

   nest_evt_prio #(.W(NUM_LVL), .IW(IW)) u_cand (
      .vec   (elig),
      .found (cand_found),
      .idx   (cand_idx)
   );

   nest_evt_nest #(.NUM_LVL(NUM_LVL), .IW(IW)) u_nest (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (grant),
      .set_idx   (cand_idx),
      .ret       (evt_ret),
      .top_found (act_found),
      .top_idx   (act_top)
   );

   always_comb begin
      grant   = cand_found && (!act_found || cand_idx < act_top);
      clr_vec = grant ? (NUM_LVL'(1) << cand_idx) : '0;
   end

   assign take_evt = grant;
   assign evt_idx  = grant ? cand_idx : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end

   // R2: the reserved level is never granted
   p_rsv_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take_evt |-> (evt_idx != RSV_IDX));

   // R7: a maskable level is granted only with its enable bit set
   p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_evt && evt_idx >= MSK_IDX) |-> mask_q[evt_idx]);

   // R10: first cycle out of reset grants the reset level
   p_boot_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      boot_q |-> (take_evt && evt_idx == IW'(LVL_RST)));

   // R1: the index is zero whenever nothing is taken
   p_idle_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !take_evt |-> (evt_idx == '0));
endmodule

// File: tb/nest_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_evt_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       emu_req = 0, nmi_pin = 0, wdog_to = 0, exc_req = 0;
   logic       hwerr_req = 0, tmr_req = 0, sw_raise = 0, mask_wr = 0, evt_ret = 0;
   logic [8:0] gp_req = '0;
   logic [3:0] sw_level = '0;
   logic [15:0] mask_wdata = '0;
   logic       take_evt;
   logic [3:0] evt_idx;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_pend, m_act, m_mask;
   logic       last_take;
   logic [3:0] last_idx;

   always #2 clk = ~clk;

   nest_evt_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .nmi_pin(nmi_pin),
      .wdog_to(wdog_to), .exc_req(exc_req), .hwerr_req(hwerr_req),
      .tmr_req(tmr_req), .gp_req(gp_req), .sw_raise(sw_raise),
      .sw_level(sw_level), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .evt_ret(evt_ret), .take_evt(take_evt), .evt_idx(evt_idx)
   );

   function automatic int first_set(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return i;
      return 16;
   endfunction

   function automatic logic [15:0] req_vec();
      logic [15:0] r = '0;
      r[0] = emu_req;
      r[2] = nmi_pin | wdog_to;
      r[3] = exc_req;
      r[5] = hwerr_req;
      r[6] = tmr_req;
      for (int i = 0; i < 9; i++) r[7+i] = gp_req[i];
      if (sw_raise && sw_level >= 4'd7) r[sw_level] = 1'b1;
      return r;
   endfunction

   function automatic int model_grant();
      logic [15:0] live = m_pend;
      logic [15:0] en = m_mask | 16'h000F;
      int c, a;
      live[3] = live[3] | exc_req;
      en[4] = 1'b0;
      c = first_set(live & en);
      a = first_set(m_act);
      if (c < 16 && c < a) return c;
      return 16;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      emu_req = 0; nmi_pin = 0; wdog_to = 0; exc_req = 0; hwerr_req = 0;
      tmr_req = 0; sw_raise = 0; mask_wr = 0; evt_ret = 0; gp_req = '0;
      sw_level = '0; mask_wdata = '0;
   endtask

   task automatic step(input string tag);
      int g;
      logic [15:0] rq;
      #1;
      g = model_grant();
      last_take = take_evt;
      last_idx  = evt_idx;
      chk({tag, " take"}, int'(take_evt), (g < 16) ? 1 : 0);
      chk({tag, " idx"}, int'(evt_idx), (g < 16) ? g : 0);
      rq = req_vec();
      @(posedge clk);
      if (evt_ret && m_act != 0) m_act[first_set(m_act)] = 1'b0;
      if (g < 16) m_act[g] = 1'b1;
      m_pend = m_pend | rq;
      if (g < 16) m_pend[g] = 1'b0;
      m_pend[4] = 1'b0;
      if (mask_wr) m_mask = mask_wdata;
      @(negedge clk);
      clear_in();
   endtask

   task automatic expect_grant(input string tag, input int tk, input int idx);
      chk({tag, " directed take"}, int'(last_take), tk);
      chk({tag, " directed idx"}, int'(last_idx), idx);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      clear_in();
      m_pend = 16'h0002; m_act = '0; m_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: forced reset-level grant in the first cycle
      step("R10"); expect_grant("R10", 1, 1);
      evt_ret = 1; step("R9");
      // R7: masked then unmasked
      gp_req[2] = 1; step("R7"); step("R7"); expect_grant("R7 masked", 0, 0);
      mask_wr = 1; mask_wdata = 16'hFFFF; step("R7");
      step("R7"); expect_grant("R7 unmasked", 1, 9);
      // R3: equal and lower blocked
      gp_req[2] = 1; gp_req[5] = 1; step("R3");
      step("R3"); expect_grant("R3 blocked", 0, 0);
      tmr_req = 1; step("R3");
      step("R3"); expect_grant("R3 preempt", 1, 6);
      // R9: return retires only the top level
      evt_ret = 1; step("R9");
      step("R9"); expect_grant("R9 one retired", 0, 0);
      evt_ret = 1; step("R9");
      step("R8"); expect_grant("R8 held pending", 1, 9);
      // R6: exception in the same cycle, ahead of hardware error
      exc_req = 1; hwerr_req = 1; step("R6"); expect_grant("R6 same cycle", 1, 3);
      step("R6"); expect_grant("R6 nested", 0, 0);
      evt_ret = 1; step("R6");
      step("R6"); expect_grant("R6 hwerr after", 1, 5);
      for (int k = 0; k < 5; k++) begin evt_ret = 1; step("R9"); end
      // R5: both sources of the nonmaskable level
      wdog_to = 1; step("R5"); step("R5"); expect_grant("R5 watchdog", 1, 2);
      evt_ret = 1; step("R5");
      nmi_pin = 1; step("R5"); step("R5"); expect_grant("R5 pin", 1, 2);
      evt_ret = 1; step("R5");
      // R2 / R4: reserved and low software targets ignored
      sw_raise = 1; sw_level = 4; step("R2"); step("R2"); expect_grant("R2 reserved", 0, 0);
      sw_raise = 1; sw_level = 3; step("R4"); step("R4"); expect_grant("R4 low level", 0, 0);
      sw_raise = 1; sw_level = 14; step("R4"); step("R4"); expect_grant("R4 sw14", 1, 14);
      sw_raise = 1; sw_level = 15; step("R4"); step("R3"); expect_grant("R3 lower blocked", 0, 0);
      evt_ret = 1; step("R9"); step("R4"); expect_grant("R4 sw15", 1, 15);
      evt_ret = 1; step("R9");
      // R1: simultaneous requests
      emu_req = 1; nmi_pin = 1; tmr_req = 1; gp_req[0] = 1; step("R1");
      step("R1"); expect_grant("R1 simultaneous", 1, 0);
      evt_ret = 1; step("R1"); step("R1"); expect_grant("R1 next", 1, 2);
      // R1: random traffic against the bench model
      void'($urandom(32'h5eed_1234));
      for (int n = 0; n < 3000; n++) begin
         emu_req   = ($urandom % 40) == 0;
         nmi_pin   = ($urandom % 30) == 0;
         wdog_to   = ($urandom % 40) == 0;
         exc_req   = ($urandom % 20) == 0;
         hwerr_req = ($urandom % 15) == 0;
         tmr_req   = ($urandom % 10) == 0;
         gp_req    = 9'($urandom) & 9'($urandom) & 9'($urandom);
         sw_raise  = ($urandom % 6) == 0;
         sw_level  = 4'($urandom);
         mask_wr   = ($urandom % 25) == 0;
         mask_wdata = 16'($urandom);
         evt_ret   = ($urandom % 3) == 0;
         step("R1");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule